// File: doc/BRIEF.md
# External Data-Memory Strobe Stretcher

This block times the read and write strobes of a data-memory transfer. A transfer starts on a machine-cycle tick when the block is idle and a request is present. It then runs for a number of machine cycles chosen by a 3-bit stretch setting. For external targets it drives one active-low strobe, which is RD for reads and WR for writes. The strobe width is counted in clocks and grows with the stretch setting.

The stretch setting is held in a small register. That register comes out of reset holding 1 and is written through a write-enable input. The setting is sampled only when a transfer starts, so a write during a transfer changes only later transfers. A transfer to internal memory always runs as the shortest transfer, whatever the setting holds, and drives no strobe. A one-clock done pulse marks the start of the last machine cycle. Busy covers the whole transfer, and a request that is still held when busy falls is taken on the next tick.

Top module: `xmem_strobe_gen`

## Requirements
- R1: After reset, rd_no and wr_no are high, busy_o and done_o are low, and the stretch register holds 1. The first external transfer after reset therefore lasts 3 machine cycles.
- R2: For an external transfer, stretch settings 0, 1, 2 and 3 give busy_o for 2, 3, 4 and 5 machine cycles, measured from the accepting tick to the tick that ends the transfer.
- R3: For an external transfer, stretch settings 4, 5, 6 and 7 give busy_o for 9, 10, 11 and 12 machine cycles.
- R4: The strobe goes active on the clock that accepts the transfer. It stays active for UNIT_CLKS/2 clocks at stretch 0 and for stretch*UNIT_CLKS clocks at stretch 1 to 7. If the final machine cycle starts first, the strobe is cut off at that point.
- R5: A read (wr_i = 0) drives only rd_no low and a write (wr_i = 1) drives only wr_no low. The two strobes are never low together.
- R6: When int_tgt_i is high at acceptance, the transfer lasts 2 machine cycles for any stretch setting, and neither strobe goes low.
- R7: done_o is high for exactly one clock, starting at the tick that opens the final machine cycle. Both strobes are high throughout the final machine cycle.
- R8: A request is accepted only on a clock where mc_tick_i is high and the block is idle. A request held through a transfer is accepted on the first tick after busy_o falls.
- R9: A stretch write made while a transfer is running does not change that transfer's length or strobe width. The next transfer uses the new value.
- R10: When stretch_we_i is high on a clock edge, the stretch register loads stretch_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mc_tick_i | input | 1 | One-clock pulse at each machine-cycle boundary |
| req_i | input | 1 | Transfer request, level |
| wr_i | input | 1 | Direction: 1 = write, 0 = read |
| int_tgt_i | input | 1 | Target is internal memory |
| stretch_i | input | 3 | New stretch setting |
| stretch_we_i | input | 1 | Load stretch_i into the stretch register |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-clock pulse at the start of the final machine cycle |

## Verification
All eight stretch settings are run as external transfers, with reads and writes alternating. This exposes the jump in cycle count between settings 3 and 4 and any mix-up between the two strobe lines. Internal-target transfers are run with a long setting programmed, which shows whether the block ignores the setting and keeps both strobes quiet. A fast machine-cycle tick is used so that the final-cycle cutoff, rather than the programmed width, ends the strobe. Two further sequences cover timing: a request held across the end of a transfer, and a stretch write made in the middle of one. Together they check when requests are accepted and when a new setting takes effect.

// File: rtl/xs_pkg.sv
package xs_pkg;
  localparam int LEN_W = 4;
  typedef logic [LEN_W-1:0] len_t;
  typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} dir_e;
endpackage

// File: rtl/xs_decode.sv
module xs_decode
  import xs_pkg::*;
#(
  parameter int UNIT_CLKS = 4,
  parameter int WID_W     = 5
) (
  input  logic [2:0]       stretch_i,
  input  logic             internal_i,
  output len_t             len_o,
  output logic [WID_W-1:0] width_o
);
  logic [2:0] eff;
  int         wtmp;

  assign eff = internal_i ? 3'd0 : stretch_i;

  // cycle count jumps by 4 between settings 3 and 4
  always_comb begin
    if (eff[2]) len_o = len_t'(eff) + len_t'(5);
    else        len_o = len_t'(eff) + len_t'(2);
  end

  always_comb begin
    if (eff == 3'd0) wtmp = UNIT_CLKS / 2;
    else             wtmp = int'(eff) * UNIT_CLKS;
    width_o = WID_W'(wtmp);
  end
endmodule

// File: rtl/xs_seq.sv
module xs_seq
  import xs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic req_i,
  input  len_t len_i,
  output logic start_o,
  output logic final_o,
  output logic busy_o,
  output logic done_o
);
  logic busy_q, done_q;
  len_t cnt_q, len_q;

  assign start_o = tick_i & req_i & ~busy_q & ~done_q;
  assign final_o = busy_q & tick_i & (cnt_q == len_q - len_t'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= len_t'(2);
    end else begin
      done_q <= final_o;
      if (start_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        len_q  <= len_i;
      end else if (busy_q && tick_i) begin
        cnt_q <= cnt_q + len_t'(1);
        if (cnt_q == len_q - len_t'(1)) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/xs_strobe.sv
module xs_strobe
  import xs_pkg::*;
#(
  parameter int WID_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ext_i,
  input  dir_e             dir_i,
  input  logic [WID_W-1:0] width_i,
  input  logic             kill_i,
  output logic             rd_no,
  output logic             wr_no
);
  logic             on_q;
  dir_e             dir_q;
  logic [WID_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q  <= 1'b0;
      dir_q <= DIR_RD;
      rem_q <= '0;
    end else if (start_i) begin
      on_q  <= ext_i;
      dir_q <= dir_i;
      rem_q <= width_i;
    end else if (on_q) begin
      rem_q <= rem_q - WID_W'(1);
      if (kill_i || rem_q == WID_W'(1)) on_q <= 1'b0;
    end
  end

  assign rd_no = ~(on_q & (dir_q == DIR_RD));
  assign wr_no = ~(on_q & (dir_q == DIR_WR));
endmodule

// File: rtl/xmem_strobe_gen.sv
module xmem_strobe_gen
  import xs_pkg::*;
#(
  parameter int UNIT_CLKS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mc_tick_i,
  input  logic       req_i,
  input  logic       wr_i,
  input  logic       int_tgt_i,
  input  logic [2:0] stretch_i,
  input  logic       stretch_we_i,
  output logic       rd_no,
  output logic       wr_no,
  output logic       busy_o,
  output logic       done_o
);
  localparam int WID_W = $clog2(7 * UNIT_CLKS + 1);

  logic [2:0]       stretch_q;
  logic             int_q;
  len_t             len;
  logic [WID_W-1:0] width;
  logic             start, final_c;
  dir_e             dir;

  assign dir = wr_i ? DIR_WR : DIR_RD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           stretch_q <= 3'd1;
    else if (stretch_we_i) stretch_q <= stretch_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    int_q <= 1'b0;
    else if (start) int_q <= int_tgt_i;
  end

  xs_decode #(.UNIT_CLKS(UNIT_CLKS), .WID_W(WID_W)) u_dec (
    .stretch_i (stretch_q),
    .internal_i(int_tgt_i),
    .len_o     (len),
    .width_o   (width)
  );

  xs_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (mc_tick_i),
    .req_i  (req_i),
    .len_i  (len),
    .start_o(start),
    .final_o(final_c),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  xs_strobe #(.WID_W(WID_W)) u_stb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .ext_i  (~int_tgt_i),
    .dir_i  (dir),
    .width_i(width),
    .kill_i (final_c),
    .rd_no  (rd_no),
    .wr_no  (wr_no)
  );
endmodule

// File: rtl/xmem_strobe_gen_chk.sv
module xmem_strobe_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mc_tick_i,
  input logic busy_i,
  input logic done_i,
  input logic rd_ni,
  input logic wr_ni,
  input logic int_q_i
);
  assert_excl_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_ni && !wr_ni));

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  assert_final_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (rd_ni && wr_ni));

  assert_done_in_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> busy_i);

  assert_idle_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (rd_ni && wr_ni));

  assert_strobe_with_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rd_ni) || $fell(wr_ni)) |-> $rose(busy_i));

  assert_internal_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && int_q_i) |-> (rd_ni && wr_ni));

  assert_start_on_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(mc_tick_i));
endmodule

bind xmem_strobe_gen xmem_strobe_gen_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mc_tick_i(mc_tick_i),
  .busy_i   (busy_o),
  .done_i   (done_o),
  .rd_ni    (rd_no),
  .wr_ni    (wr_no),
  .int_q_i  (int_q)
);

// File: tb/xmem_strobe_gen_bench.sv
`timescale 1ns/1ps
module xmem_strobe_gen_bench;
  localparam int UNIT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       req = 1'b0, wr = 1'b0, intt = 1'b0, we = 1'b0;
  logic [2:0] st = 3'd0;
  logic       rd_n, wr_n, busy, done;
  int         div = 8;
  int         tcnt = 0;
  int         checks = 0, errors = 0, clocks = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (tcnt >= div - 1) begin tcnt <= 0; tick <= 1'b1; end
    else begin tcnt <= tcnt + 1; tick <= 1'b0; end
  end

  xmem_strobe_gen #(.UNIT_CLKS(UNIT)) u_xmem_strobe_gen (
    .clk_i(clk), .rst_ni(rst_n), .mc_tick_i(tick), .req_i(req), .wr_i(wr),
    .int_tgt_i(intt), .stretch_i(st), .stretch_we_i(we),
    .rd_no(rd_n), .wr_no(wr_n), .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) begin
    clocks <= clocks + 1;
    if (clocks > 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog expired actual %0d expected below 150000", clocks);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_len(input int s);
    return (s < 4) ? s + 2 : s + 5;
  endfunction

  function automatic int exp_wid(input int s, input int n);
    int w;
    w = (s == 0) ? UNIT / 2 : s * UNIT;
    return (w < (n - 1) * div) ? w : (n - 1) * div;
  endfunction

  task automatic set_stretch(input int v);
    @(negedge clk);
    st = 3'(v);
    we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic run_xfer(input string tag, input logic is_wr, input logic is_int,
                          input int exp_n, input int exp_w,
                          input bit mid_en, input int mid_val);
    int busy_c, rd_c, wr_c, done_c, done_idx, idx;
    busy_c = 0; rd_c = 0; wr_c = 0; done_c = 0; done_idx = -1; idx = 0;
    @(negedge clk);
    wr = is_wr; intt = is_int; req = 1'b1;
    for (int k = 0; k < 200 && !busy; k++) @(negedge clk);
    chk(tag, "request accepted", int'(busy), 1);
    req = 1'b0;
    while (busy && idx < 2000) begin
      busy_c++;
      if (!rd_n) rd_c++;
      if (!wr_n) wr_c++;
      if (done) begin done_c++; done_idx = idx; end
      if (mid_en && idx == 2) begin st = 3'(mid_val); we = 1'b1; end
      else we = 1'b0;
      idx++;
      @(negedge clk);
    end
    we = 1'b0;
    chk(tag, "busy clocks", busy_c, exp_n * div);
    chk("R5", "active strobe clocks", is_wr ? wr_c : rd_c, exp_w);
    chk("R5", "other strobe clocks", is_wr ? rd_c : wr_c, 0);
    chk("R7", "done clocks", done_c, 1);
    chk("R7", "done position", done_idx, (exp_n - 1) * div);
  endtask

  task automatic t_reset();
    chk("R1", "rd_no", int'(rd_n), 1);
    chk("R1", "wr_no", int'(wr_n), 1);
    chk("R1", "busy_o", int'(busy), 0);
    chk("R1", "done_o", int'(done), 0);
    run_xfer("R1", 1'b0, 1'b0, 3, exp_wid(1, 3), 1'b0, 0);
  endtask

  task automatic t_short();
    for (int s = 0; s < 4; s++) begin
      set_stretch(s);
      run_xfer("R2", logic'(s % 2), 1'b0, exp_len(s), exp_wid(s, exp_len(s)), 1'b0, 0);
    end
  endtask

  task automatic t_long();
    for (int s = 4; s < 8; s++) begin
      set_stretch(s);
      run_xfer("R3", logic'(s % 2), 1'b0, exp_len(s), exp_wid(s, exp_len(s)), 1'b0, 0);
    end
  endtask

  task automatic t_internal();
    set_stretch(6);
    run_xfer("R6", 1'b0, 1'b1, 2, 0, 1'b0, 0);
    run_xfer("R6", 1'b1, 1'b1, 2, 0, 1'b0, 0);
    intt = 1'b0;
  endtask

  task automatic t_fast_tick();
    div = 2;
    repeat (4) @(negedge clk);
    set_stretch(3);
    run_xfer("R4", 1'b1, 1'b0, 5, exp_wid(3, 5), 1'b0, 0);
    set_stretch(0);
    run_xfer("R4", 1'b0, 1'b0, 2, exp_wid(0, 2), 1'b0, 0);
    div = 8;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_holdoff();
    int gap;
    gap = 0;
    set_stretch(1);
    @(negedge clk);
    wr = 1'b0; req = 1'b1;
    for (int k = 0; k < 200 && !busy; k++) @(negedge clk);
    for (int k = 0; k < 500 && busy; k++) @(negedge clk);
    for (int k = 0; k < 200 && !busy; k++) begin gap++; @(negedge clk); end
    chk("R8", "idle clocks before held request", gap, div);
    req = 1'b0;
    for (int k = 0; k < 500 && busy; k++) @(negedge clk);
    chk("R8", "busy after held transfer", int'(busy), 0);
  endtask

  task automatic t_midwrite();
    set_stretch(2);
    run_xfer("R9", 1'b0, 1'b0, 4, exp_wid(2, 4), 1'b1, 5);
    run_xfer("R10", 1'b1, 1'b0, 10, exp_wid(5, 10), 1'b0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short();
    t_long();
    t_internal();
    t_fast_tick();
    t_holdoff();
    t_midwrite();
    repeat (5) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule